// File: doc/BRIEF.md
# Fast Single-Word Interrupt Channel Bank

This block holds eight independent one-word message slots. Each slot has its own 32-bit register. When a sender writes a slot, the block keeps the word and raises that slot's pending flag in a shared status word, in the same clock edge. No separate trigger write is needed. The pending flags are masked by a receiver-side enable register, and any flag that is both pending and enabled drives the receiver interrupt line high.

The receiver services a slot in two steps. It first writes a one to the slot's flag position in the clear register, then reads the slot register to fetch the word. Nothing is returned to the sender: there is no acknowledge and no sender interrupt. All accesses use one word-wide register port. Writes are synchronous. Reads are combinational from the read address.

Top module: `fastch_bank`

## Requirements
- R1: Slot n (n = 0..7) is a 32-bit register at byte offset 0x8C + 4*n. A write there stores the data. A read there returns the last word written. Clearing the slot's flag does not change the stored word.
- R2: A write to slot n sets bit 9+n of the status word, which is read at offset 0xC8. All other status bits keep their values. The flag is visible from the clock edge that takes the write.
- R3: A second write to a slot before its flag is cleared replaces the stored word. The flag stays set.
- R4: Writing the clear register at offset 0xC4 clears each status bit 9+n whose data bit is one. Zero data bits have no effect.
- R5: The enable register at offset 0xC0 keeps only bits 9..16; every other bit reads zero. `irq_rx` is high exactly when at least one status bit and the matching enable bit are both set.
- R6: Reset clears all slot words, the status flags and the enable register, and drives `irq_rx` low.
- R7: These have no effect on any register: writes to offsets that are not decoded, and writes to the status offset. Reads of offsets that are not decoded, and reads of the clear offset, return zero. Status bits outside 9..16 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| irq_rx | output | 1 | Receiver interrupt |

## Verification
The assertions assume that `wr_addr` is stable and known whenever `wr_en` is high. They also assume that the only writes that change state are single-cycle strobes on the one write port. This means a slot write and a clear can never reach the same flag in the same cycle.

The stimulus meets these assumptions in two ways:
- It changes `wr_en`, `wr_addr` and `wr_data` only on the falling edge, and drops `wr_en` after one cycle.
- It samples `rd_data` and `irq_rx` on the following falling edge.

The stimulus covers masked and unmasked slots, overwrite without a clear, and clears with all-ones and all-zero data. It also covers undecoded offsets and a reset in the middle of the run.

// File: rtl/fastch_pkg.sv
package fastch_pkg;
    localparam int NUM_CH   = 8;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int STAT_LSB = 9;
    localparam int STRIDE   = 4;

    localparam logic [ADDR_W-1:0] CH_BASE  = 8'h8C;
    localparam logic [ADDR_W-1:0] EN_OFF   = 8'hC0;
    localparam logic [ADDR_W-1:0] CLR_OFF  = 8'hC4;
    localparam logic [ADDR_W-1:0] STAT_OFF = 8'hC8;

    typedef struct packed {
        logic [NUM_CH-1:0] ch;
        logic              en;
        logic              clr;
        logic              stat;
    } hit_t;

    typedef struct packed {
        logic [NUM_CH-1:0] stat;
        logic [NUM_CH-1:0] en;
    } flag_state_t;
endpackage

// File: rtl/fastch_decode.sv
module fastch_decode
    import fastch_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    logic [NUM_CH-1:0] ch_hit;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(int'(CH_BASE) + STRIDE * n);
        assign ch_hit[n] = (addr == SLOT_ADDR);
    end

    always_comb begin
        hit      = '0;
        hit.ch   = ch_hit;
        hit.en   = (addr == EN_OFF);
        hit.clr  = (addr == CLR_OFF);
        hit.stat = (addr == STAT_OFF);
    end
endmodule

// File: rtl/fastch_store.sv
module fastch_store
    import fastch_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0]              sel,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_CH-1:0][DATA_W-1:0]  words
);
    logic [NUM_CH-1:0][DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        for (int n = 0; n < NUM_CH; n++) begin
            if (sel[n]) word_d[n] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign words = word_q;
endmodule

// File: rtl/fastch_flags.sv
module fastch_flags
    import fastch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set,
    input  logic              en_wr,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] field,
    output logic [NUM_CH-1:0] stat,
    output logic [NUM_CH-1:0] en,
    output logic              irq
);
    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_wr) state_d.stat = state_q.stat & ~field;
        state_d.stat = state_d.stat | set;
        if (en_wr)  state_d.en = field;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign stat = state_q.stat;
    assign en   = state_q.en;
    assign irq  = |(state_q.stat & state_q.en);
endmodule

// File: rtl/fastch_bank.sv
module fastch_bank
    import fastch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_rx
);
    hit_t                          wr_hit, rd_hit;
    logic [NUM_CH-1:0]             slot_wr;
    logic [NUM_CH-1:0]             stat_bits, en_bits;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_words;

    fastch_decode u_wr_dec (.addr(wr_addr), .hit(wr_hit));
    fastch_decode u_rd_dec (.addr(rd_addr), .hit(rd_hit));

    assign slot_wr = wr_hit.ch & {NUM_CH{wr_en}};

    fastch_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (slot_wr),
        .wdata (wr_data),
        .words (ch_words)
    );

    fastch_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (slot_wr),
        .en_wr  (wr_en & wr_hit.en),
        .clr_wr (wr_en & wr_hit.clr),
        .field  (wr_data[STAT_LSB +: NUM_CH]),
        .stat   (stat_bits),
        .en     (en_bits),
        .irq    (irq_rx)
    );

    always_comb begin
        rd_data = '0;
        if (rd_hit.stat) rd_data[STAT_LSB +: NUM_CH] = stat_bits;
        if (rd_hit.en)   rd_data[STAT_LSB +: NUM_CH] = en_bits;
        if (rd_hit.clr)  rd_data = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (rd_hit.ch[n]) rd_data = ch_words[n];
        end
    end
endmodule

// File: rtl/fastch_bank_chk.sv
module fastch_bank_chk
    import fastch_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic [NUM_CH-1:0]             stat,
    input logic [NUM_CH-1:0][DATA_W-1:0] words,
    input logic                          irq_rx
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] A = ADDR_W'(int'(CH_BASE) + STRIDE * n);

        assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A) |=> (words[n] == $past(wr_data)));

        assert_word_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == A) |=> $stable(words[n]));

        assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A) |=> stat[n]);

        assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[n] && !(wr_en && wr_addr == CLR_OFF && wr_data[STAT_LSB + n]))
            |=> stat[n]);

        assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == CLR_OFF && wr_data[STAT_LSB + n]) |=> !stat[n]);
    end

    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(irq_rx));
endmodule

bind fastch_bank fastch_bank_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .stat    (stat_bits),
    .words   (ch_words),
    .irq_rx  (irq_rx)
);

// File: tb/tb_fastch_bank.sv
`timescale 1ns/1ps
module tb_fastch_bank;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_rx;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fastch_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_rx(irq_rx)
    );

    // {addr, data, expected status word, expected irq}
    localparam int NV = 11;
    localparam logic [72:0] VEC [NV] = '{
        {8'hC0, 32'h0000_1E00, 32'h0000_0000, 1'b0},
        {8'h8C, 32'hA5A5_0001, 32'h0000_0200, 1'b1},
        {8'hC4, 32'h0000_0200, 32'h0000_0000, 1'b0},
        {8'hA8, 32'h1234_5678, 32'h0001_0000, 1'b0},
        {8'h98, 32'hDEAD_BEEF, 32'h0001_1000, 1'b1},
        {8'hC4, 32'h0000_1000, 32'h0001_0000, 1'b0},
        {8'hC0, 32'h0001_0000, 32'h0001_0000, 1'b1},
        {8'hC4, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
        {8'h94, 32'h0000_0001, 32'h0000_0800, 1'b0},
        {8'h50, 32'hFFFF_FFFF, 32'h0000_0800, 1'b0},
        {8'hC8, 32'hFFFF_FFFF, 32'h0000_0800, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_run++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_w [8];
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R6: reset state
        rd(8'hC8, v); check("R6 status", v, 32'h0);
        rd(8'hC0, v); check("R6 enable", v, 32'h0);
        check("R6 irq", {31'h0, irq_rx}, 32'h0);
        for (int n = 0; n < 8; n++) begin
            rd(8'(8'h8C + 4 * n), v); check("R6 slot word", v, 32'h0);
        end

        // Table: R2 R4 R5 R7
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][72:65], VEC[i][64:33]);
            rd(8'hC8, v);
            check("R2 R4 R7 table status", v, VEC[i][32:1]);
            check("R5 table irq", {31'h0, irq_rx}, {31'h0, VEC[i][0]});
        end

        // R1: words kept and unchanged by clears
        for (int n = 0; n < 8; n++) exp_w[n] = 32'h0;
        exp_w[0] = 32'hA5A5_0001; exp_w[2] = 32'h0000_0001;
        exp_w[3] = 32'hDEAD_BEEF; exp_w[7] = 32'h1234_5678;
        for (int n = 0; n < 8; n++) begin
            rd(8'(8'h8C + 4 * n), v); check("R1 slot word", v, exp_w[n]);
        end

        // R3: overwrite before clear
        wr(8'hA0, 32'h0000_0011);
        wr(8'hA0, 32'h0000_0022);
        rd(8'hA0, v); check("R3 overwrite word", v, 32'h0000_0022);
        rd(8'hC8, v); check("R3 flag stays", v, 32'h0000_4800);
        check("R5 masked irq", {31'h0, irq_rx}, 32'h0);

        // R5: enable readback and unmask
        rd(8'hC0, v); check("R5 enable readback", v, 32'h0001_0000);
        wr(8'hC0, 32'hFFFF_FFFF);
        rd(8'hC0, v); check("R5 enable field only", v, 32'h0001_FE00);
        check("R5 irq unmasked", {31'h0, irq_rx}, 32'h1);

        // R4: zero clear data has no effect
        wr(8'hC4, 32'h0);
        rd(8'hC8, v); check("R4 zero clear", v, 32'h0000_4800);

        // R7: undecoded and clear offset reads
        rd(8'h50, v); check("R7 undecoded read", v, 32'h0);
        rd(8'h8D, v); check("R7 misaligned read", v, 32'h0);
        rd(8'hC4, v); check("R7 clear reg read", v, 32'h0);

        // R6: reset mid-run
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(8'hC8, v); check("R6 status after reset", v, 32'h0);
        rd(8'hA0, v); check("R6 word after reset", v, 32'h0);
        check("R6 irq after reset", {31'h0, irq_rx}, 32'h0);

        done = 1;
        finish_run();
    end
endmodule